// File: doc/BRIEF.md
# Windowed Data Address Translator

This block turns a 16-bit logical data address into a physical target and an offset inside that target. The lower half of the address space goes straight to internal data RAM at the same offset. The top quarter is I/O space. The quarter in between is a 16K window, and a programmable map word points that window at one of two places: a 16K bank of instruction RAM, or a 16K slice of a 128K unified-memory segment.

The translation is purely combinational. Only the map word is held in a register, and it is loaded through a small write port (an enable and a data word). A load becomes visible at the next clock edge. The outputs are:
- a 2-bit target select;
- an 18-bit physical offset;
- the unified segment number;
- a bus-error flag for I/O addresses outside the legal range.

Top module: `dwin_xlate`

## Requirements
- R1: A logical address from 0x0000 to 0x7FFF selects data RAM (target code 0) with an offset equal to the address.
- R2: An address whose top two bits are both set and which lies in 0xFF00 to 0xFF0F selects data RAM (code 0) at that address, with the bus-error flag low.
- R3: Any other address from 0xC000 to 0xFFFF raises the bus-error flag. It still selects data RAM (code 0) with the offset equal to the address.
- R4: For 0x8000 to 0xBFFF with map bit 12 set, the target is instruction RAM (code 1). The offset is map[3:0] times 0x4000 plus (address − 0x8000).
- R5: For 0x8000 to 0xBFFF with map bit 12 clear, the target is unified memory (code 2). The segment number is map[9:3] and the offset is map[2:0] times 0x4000 plus (address − 0x8000). Map bits 10, 11 and 13 to 15 have no effect.
- R6: After reset the map word is 0x0000, so the window selects unified segment 0, slice 0.
- R7: Address input bits above bit 15 have no effect on any output.
- R8: A map write changes the translation only from the next rising clock edge. During the write cycle the old value still applies.
- R9: The segment number output is 0 unless the target is unified memory. The bus-error flag is low for every address below 0xC000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| mapWrEn | input | 1 | Load strobe for the map word |
| mapWrData | input | 16 | New map word |
| addrIn | input | 24 | Logical address; only bits 15:0 are decoded |
| tgtSel | output | 2 | Target: 0 data RAM, 1 instruction RAM, 2 unified memory |
| physOff | output | 18 | Byte offset inside the selected target |
| segNum | output | 7 | Unified segment number |
| busErr | output | 1 | Illegal I/O address |

## Verification
The bench probes the edges of each region: 0x7FFF against 0x8000, 0xBFFF against 0xC000, and 0xFF00/0xFF0F against their neighbours 0xFEFF and 0xFF10. A decoder with an off-by-one region compare would route one of those addresses to the wrong target or flag the wrong I/O word.

Map words use the highest bank and segment values and set the unused bits. A design that slices the wrong map field, or lets bits 10, 11 or 13 to 15 leak in, would return a shifted offset or segment.

The bench samples the output both between a map write and its clock edge and after that edge. This catches a write-through bypass, which would make the new mapping appear one cycle early. Addresses that differ only above bit 15 expose a decoder that reads the full input.

// File: rtl/dwin_pkg.sv
package dwin_pkg;

  localparam int MAP_W      = 16;
  localparam int WIN_BITS   = 14;  // 16K window
  localparam int BANK_W     = 4;   // instruction RAM bank field width
  localparam int SLICE_W    = 3;   // 16K slices per 128K segment
  localparam int SEG_W      = 7;   // unified segment field width
  localparam int IRAM_BIT   = 12;  // map bit choosing instruction RAM
  localparam int SLICE_LSB  = 0;
  localparam int SEG_LSB    = 3;
  localparam int BANK_LSB   = 0;

  typedef enum logic [1:0] {
    TGT_DRAM = 2'd0,
    TGT_IRAM = 2'd1,
    TGT_UMEM = 2'd2
  } tgt_e;

  typedef struct packed {
    logic               iramSel;
    logic [BANK_W-1:0]  iramBank;
    logic [SEG_W-1:0]   umemSeg;
    logic [SLICE_W-1:0] umemSlice;
  } mapStrobe_t;

endpackage

// File: rtl/dwin_mapctl.sv
module dwin_mapctl
  import dwin_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             mapWrEn,
  input  logic [MAP_W-1:0] mapWrData,
  output logic [MAP_W-1:0] mapWord,
  output mapStrobe_t       strobes
);

  logic [MAP_W-1:0] mapQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        mapQ <= '0;
    else if (mapWrEn) mapQ <= mapWrData;
  end

  always_comb begin
    strobes.iramSel   = mapQ[IRAM_BIT];
    strobes.iramBank  = mapQ[BANK_LSB +: BANK_W];
    strobes.umemSeg   = mapQ[SEG_LSB +: SEG_W];
    strobes.umemSlice = mapQ[SLICE_LSB +: SLICE_W];
  end

  assign mapWord = mapQ;

  // R8: without a write strobe the map word holds
  p_map_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !mapWrEn |=> $stable(mapQ));

  // R8: a write strobe loads the data presented in that cycle
  p_map_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    mapWrEn |=> (mapQ == $past(mapWrData)));

endmodule

// File: rtl/dwin_xlate_dp.sv
module dwin_xlate_dp
  import dwin_pkg::*;
#(
  parameter int OFF_W = WIN_BITS + BANK_W
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic [15:0]      addr,
  input  mapStrobe_t       strobes,
  output logic [1:0]       tgtSel,
  output logic [OFF_W-1:0] physOff,
  output logic [SEG_W-1:0] segNum,
  output logic             busErr
);

  localparam logic [11:0] IO_LEGAL_TAG = 12'hFF0;
  localparam int          PAD_IRAM     = OFF_W - WIN_BITS - BANK_W;
  localparam int          PAD_UMEM     = OFF_W - WIN_BITS - SLICE_W;

  logic [WIN_BITS-1:0] winOff;
  logic                inLow;
  logic                inIo;
  tgt_e                tgtNext;

  assign winOff = addr[WIN_BITS-1:0];
  assign inLow  = ~addr[15];
  assign inIo   = addr[15] & addr[14];

  always_comb begin
    tgtNext = TGT_DRAM;
    physOff = OFF_W'(addr);
    segNum  = '0;
    busErr  = 1'b0;
    if (inLow) begin
      tgtNext = TGT_DRAM;
    end else if (inIo) begin
      tgtNext = TGT_DRAM;
      busErr  = (addr[15:4] != IO_LEGAL_TAG);
    end else if (strobes.iramSel) begin
      tgtNext = TGT_IRAM;
      physOff = {{PAD_IRAM{1'b0}}, strobes.iramBank, winOff};
    end else begin
      tgtNext = TGT_UMEM;
      physOff = {{PAD_UMEM{1'b0}}, strobes.umemSlice, winOff};
      segNum  = strobes.umemSeg;
    end
  end

  assign tgtSel = tgtNext;

  // R1: the low half always reaches data RAM unchanged
  p_low_direct_r1: assert property (@(posedge clk) disable iff (!rstN)
    (addr < 16'h8000) |-> (tgtSel == 2'd0 && physOff == OFF_W'(addr)));

  // R3: an error is only ever flagged on a data RAM access in I/O space
  p_err_in_io_r3: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> (tgtSel == 2'd0 && addr >= 16'hC000));

  // R9: segment number is quiet outside unified memory
  p_seg_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (tgtSel != 2'd2) |-> (segNum == '0));

  // R4: an instruction RAM offset never leaves the window's bank
  p_iram_bank_r4: assert property (@(posedge clk) disable iff (!rstN)
    (tgtSel == 2'd1) |-> (physOff[WIN_BITS +: BANK_W] == strobes.iramBank));

endmodule

// File: rtl/dwin_xlate.sv
module dwin_xlate
  import dwin_pkg::*;
#(
  parameter int IN_ADDR_W = 24,
  parameter int OFF_W     = WIN_BITS + BANK_W
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 mapWrEn,
  input  logic [MAP_W-1:0]     mapWrData,
  input  logic [IN_ADDR_W-1:0] addrIn,
  output logic [1:0]           tgtSel,
  output logic [OFF_W-1:0]     physOff,
  output logic [SEG_W-1:0]     segNum,
  output logic                 busErr
);

  mapStrobe_t       strobes;
  logic [MAP_W-1:0] mapWord;

  dwin_mapctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .mapWrEn   (mapWrEn),
    .mapWrData (mapWrData),
    .mapWord   (mapWord),
    .strobes   (strobes)
  );

  dwin_xlate_dp #(.OFF_W(OFF_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .addr    (addrIn[15:0]),
    .strobes (strobes),
    .tgtSel  (tgtSel),
    .physOff (physOff),
    .segNum  (segNum),
    .busErr  (busErr)
  );

  // R7: changes above bit 15 alone leave every output unchanged
  generate
    if (IN_ADDR_W > 16) begin : g_upper
      p_upper_ignored_r7: assert property (@(posedge clk) disable iff (!rstN)
        (!$stable(addrIn[IN_ADDR_W-1:16]) && $stable(addrIn[15:0]) && $stable(mapWord))
        |-> ($stable(tgtSel) && $stable(physOff) && $stable(segNum) && $stable(busErr)));
    end
  endgenerate

endmodule

// File: tb/dwin_xlate_tb.sv
module dwin_xlate_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mapWrEn = 1'b0;
  logic [15:0] mapWrData = '0;
  logic [23:0] addrIn = '0;
  logic [1:0]  tgtSel;
  logic [17:0] physOff;
  logic [6:0]  segNum;
  logic        busErr;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dwin_xlate u_dut (
    .clk(clk), .rstN(rstN), .mapWrEn(mapWrEn), .mapWrData(mapWrData),
    .addrIn(addrIn), .tgtSel(tgtSel), .physOff(physOff),
    .segNum(segNum), .busErr(busErr)
  );

  task automatic probe(input string tag, input logic [23:0] a, input logic [1:0] eSel,
                       input logic [17:0] eOff, input logic [6:0] eSeg, input logic eErr);
    addrIn = a;
    #1;
    vectors++;
    if (tgtSel !== eSel || physOff !== eOff || segNum !== eSeg || busErr !== eErr) begin
      misses++;
      $display("FAIL %s addr=%h got sel=%0d off=%h seg=%h err=%b exp sel=%0d off=%h seg=%h err=%b",
               tag, a, tgtSel, physOff, segNum, busErr, eSel, eOff, eSeg, eErr);
    end
  endtask

  task automatic setMap(input logic [15:0] v);
    @(negedge clk);
    mapWrEn = 1'b1; mapWrData = v;
    @(negedge clk);
    mapWrEn = 1'b0;
  endtask

  task automatic testReset();
    probe("R6 reset window", 24'h8000, 2'd2, 18'h00000, 7'h00, 1'b0);
    probe("R6 reset window top", 24'hBFFF, 2'd2, 18'h03FFF, 7'h00, 1'b0);
  endtask

  task automatic testLow();
    probe("R1 zero", 24'h0000, 2'd0, 18'h00000, 7'h00, 1'b0);
    probe("R1 mid", 24'h1234, 2'd0, 18'h01234, 7'h00, 1'b0);
    probe("R1 top", 24'h7FFF, 2'd0, 18'h07FFF, 7'h00, 1'b0);
  endtask

  task automatic testIo();
    probe("R2 first legal", 24'hFF00, 2'd0, 18'h0FF00, 7'h00, 1'b0);
    probe("R2 last legal", 24'hFF0F, 2'd0, 18'h0FF0F, 7'h00, 1'b0);
    probe("R3 io base", 24'hC000, 2'd0, 18'h0C000, 7'h00, 1'b1);
    probe("R3 below legal", 24'hFEFF, 2'd0, 18'h0FEFF, 7'h00, 1'b1);
    probe("R3 above legal", 24'hFF10, 2'd0, 18'h0FF10, 7'h00, 1'b1);
    probe("R3 io top", 24'hFFFF, 2'd0, 18'h0FFFF, 7'h00, 1'b1);
  endtask

  task automatic testIram();
    setMap(16'h1005);
    probe("R4 bank5 base", 24'h8000, 2'd1, 18'h14000, 7'h00, 1'b0);
    probe("R4 bank5 top", 24'hBFFF, 2'd1, 18'h17FFF, 7'h00, 1'b0);
    setMap(16'hFFFF);
    probe("R4 bank15 mid", 24'hA123, 2'd1, 18'h3E123, 7'h00, 1'b0);
    probe("R9 low unaffected", 24'h7FFF, 2'd0, 18'h07FFF, 7'h00, 1'b0);
  endtask

  task automatic testUmem();
    setMap(16'h03FF);
    probe("R5 seg7F slice7", 24'h8001, 2'd2, 18'h1C001, 7'h7F, 1'b0);
    setMap(16'hEC25);
    probe("R5 unused bits ignored", 24'h9000, 2'd2, 18'h15000, 7'h04, 1'b0);
    probe("R9 io unaffected", 24'hFF05, 2'd0, 18'h0FF05, 7'h00, 1'b0);
  endtask

  task automatic testUpper();
    setMap(16'h1002);
    probe("R7 upper low", 24'hAB1234, 2'd0, 18'h01234, 7'h00, 1'b0);
    probe("R7 upper io", 24'hFFFF00, 2'd0, 18'h0FF00, 7'h00, 1'b0);
    probe("R7 upper window", 24'h5A8010, 2'd1, 18'h08010, 7'h00, 1'b0);
  endtask

  task automatic testWriteTiming();
    setMap(16'h0000);
    @(negedge clk);
    mapWrEn = 1'b1; mapWrData = 16'h1003;
    probe("R8 old map during write", 24'h8004, 2'd2, 18'h00004, 7'h00, 1'b0);
    @(negedge clk);
    mapWrEn = 1'b0; mapWrData = 16'h0000;
    probe("R8 new map after edge", 24'h8004, 2'd1, 18'h0C004, 7'h00, 1'b0);
    @(negedge clk);
    probe("R8 held without strobe", 24'h8004, 2'd1, 18'h0C004, 7'h00, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLow();
    testIo();
    testIram();
    testUmem();
    testUpper();
    testWriteTiming();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule